// File: doc/BRIEF.md
# Battery FET enable controller

This block produces the enable levels for the charge FET, the discharge FET and an optional pre-charge FET of a battery pack monitor. Software asks for each FET through a single control register (write strobe plus data) and reads back a status word. That word shows the stored requests, the live outputs and whether a protection lockout is in force.

An autonomous current-protection unit can override software at any time. While its input is high, every FET enable is held low and the stored requests are wiped. After the input drops, a hold-off counter keeps rejecting software writes for a fixed number of clock cycles. That count is a parameter sized for one second of system clock. Once the hold-off ends, nothing turns on by itself: software must write the enables again.

A separate power-off input also forces the outputs low. It keeps the requests and does not start the hold-off. A mode input chooses between normal operation and deep-undervoltage recovery. Only recovery mode lets the pre-charge enable go high.

Top module: `fet_enable_ctrl`

## Requirements
- R1: Two clock edges after `prot_in` rises, `chg_en`, `dsg_en` and `pre_en` are all 0, and they stay 0 while it is held.
- R2: One edge after the synchronized protection level is seen, the request bits (status bits 0, 1 and 2) read 0.
- R3: After `prot_in` falls, status bit 6 (lockout) stays 1 until the edge numbered HOLD_CYC+2 after the fall. It reads 0 from that edge on.
- R4: A write while lockout is 1 leaves the requests and the outputs unchanged.
- R5: A write outside lockout stores `wr_data` bit 0 as the charge request, bit 1 as the discharge request and bit 2 as the pre-charge request. Outputs follow from the edge that takes the write.
- R6: When lockout ends, the outputs stay 0 until software writes the enables again.
- R7: `pre_en` can be 1 only when `mode_normal` is 0 and the pre-charge request is set. With `mode_normal` at 1 it is 0.
- R8: Two edges after `poweroff_in` rises, all enables are 0. The requests are kept, lockout stays 0, and the outputs come back once the input is released.
- R9: Status layout: bit 0 charge request, bit 1 discharge request, bit 2 pre-charge request, bit 3 `chg_en`, bit 4 `dsg_en`, bit 5 `pre_en`, bit 6 lockout, bit 7 zero. Write data in bits 3 to 7 has no effect.
- R10: While `rst_n` is 0, all enables and the whole status word are 0.
- R11: If protection returns during a hold-off, the count restarts. Lockout then lasts HOLD_CYC+2 edges from the latest fall of `prot_in`.
- R12: If a write lands in the same cycle that protection first takes effect, the outputs are 0 after that edge and the requests read 0 one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_normal | input | 1 | 1 = normal operation, 0 = deep-undervoltage recovery |
| prot_in | input | 1 | Asynchronous current-protection level |
| poweroff_in | input | 1 | Asynchronous power-off level |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| status | output | 8 | Status readback word |
| chg_en | output | 1 | Charge FET enable |
| dsg_en | output | 1 | Discharge FET enable |
| pre_en | output | 1 | Pre-charge FET enable |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a software write and the first cycle in which synchronized protection takes effect. The bench lines up a write of all enables with the edge where the synchronizer output rises. It expects the outputs to be off right after that edge and the requests to be cleared one edge later.

The second pair is the last lockout cycle and a re-enable write. A write placed one edge before lockout expires must be dropped, and the outputs must stay off. A random phase then mixes protection, power-off, mode changes and writes against a bench model, so these collisions also occur by chance.

// File: rtl/fet_ctrl_pkg.sv
package fet_ctrl_pkg;
   localparam int REG_W     = 8;
   localparam int B_CHG     = 0;
   localparam int B_DSG     = 1;
   localparam int B_PRE     = 2;
   localparam int B_CHG_OUT = 3;
   localparam int B_DSG_OUT = 4;
   localparam int B_PRE_OUT = 5;
   localparam int B_LOCK    = 6;

   typedef struct packed {
      logic pre;
      logic dsg;
      logic chg;
   } fet_req_t;
endpackage

// File: rtl/fet_sync.sv
module fet_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("fet_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= d;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fet_holdoff.sv
module fet_holdoff #(
   parameter int HOLD_CYC = 8_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   output logic lockout
);
   localparam int CNT_W = $clog2(HOLD_CYC + 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (HOLD_CYC < 1) begin : g_bad
         $error("fet_holdoff: HOLD_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (trip)       cnt <= CNT_W'(HOLD_CYC);
      else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
   end

   assign lockout = trip | (cnt != '0);

   assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!trip && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

   assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> (cnt == CNT_W'(HOLD_CYC)) && lockout);
endmodule

// File: rtl/fet_req_reg.sv
module fet_req_reg
   import fet_ctrl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  fet_req_t wr_req,
   input  logic     block,
   input  logic     clear,
   output fet_req_t req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 req <= '0;
      else if (clear)             req <= '0;
      else if (wr_en && !block)   req <= wr_req;
   end

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (req == '0));

   assert_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (block && !clear) |=> $stable(req));

   assert_no_self_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req.chg) |-> $past(wr_en));
endmodule

// File: rtl/fet_enable_ctrl.sv
module fet_enable_ctrl
   import fet_ctrl_pkg::*;
#(
   parameter int HOLD_CYC      = 8_000_000,
   parameter int SYNC_STAGES   = 2,
   parameter bit HAS_PRECHARGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_normal,
   input  logic             prot_in,
   input  logic             poweroff_in,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] status,
   output logic             chg_en,
   output logic             dsg_en,
   output logic             pre_en
);
   logic     prot_s;
   logic     poff_s;
   logic     lockout;
   logic     force_off;
   fet_req_t req;
   fet_req_t wr_req;

   fet_sync #(.STAGES(SYNC_STAGES)) u_sync_prot (
      .clk(clk), .rst_n(rst_n), .d(prot_in), .q(prot_s));

   fet_sync #(.STAGES(SYNC_STAGES)) u_sync_poff (
      .clk(clk), .rst_n(rst_n), .d(poweroff_in), .q(poff_s));

   fet_holdoff #(.HOLD_CYC(HOLD_CYC)) u_holdoff (
      .clk(clk), .rst_n(rst_n), .trip(prot_s), .lockout(lockout));

   assign wr_req = '{pre: wr_data[B_PRE], dsg: wr_data[B_DSG], chg: wr_data[B_CHG]};

   fet_req_reg u_req (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_req(wr_req),
      .block(lockout), .clear(prot_s), .req(req));

   assign force_off = prot_s | poff_s | lockout;
   assign chg_en    = req.chg & ~force_off;
   assign dsg_en    = req.dsg & ~force_off;

   generate
      if (HAS_PRECHARGE) begin : g_pre
         assign pre_en = req.pre & ~mode_normal & ~force_off;
      end else begin : g_nopre
         assign pre_en = 1'b0;
      end
   endgenerate

   always_comb begin
      status            = '0;
      status[B_CHG]     = req.chg;
      status[B_DSG]     = req.dsg;
      status[B_PRE]     = req.pre;
      status[B_CHG_OUT] = chg_en;
      status[B_DSG_OUT] = dsg_en;
      status[B_PRE_OUT] = pre_en;
      status[B_LOCK]    = lockout;
   end

   assert_prot_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      prot_s |-> !chg_en && !dsg_en && !pre_en);

   assert_lock_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |-> !chg_en && !dsg_en);

   assert_pre_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_normal |-> !pre_en);

   assert_poff_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      poff_s |-> !chg_en && !dsg_en && !pre_en);

   always_comb begin
      if (!rst_n) assert_reset_R10: assert (status == '0 && !chg_en && !dsg_en && !pre_en);
   end
endmodule

// File: tb/fet_enable_ctrl_test.sv
module fet_enable_ctrl_test;
   localparam int CLK_P = 10;
   localparam int HOLD  = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_normal = 1'b1;
   logic       prot_in = 1'b0;
   logic       poweroff_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] status;
   logic       chg_en, dsg_en, pre_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   fet_enable_ctrl #(.HOLD_CYC(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .mode_normal(mode_normal), .prot_in(prot_in),
      .poweroff_in(poweroff_in), .wr_en(wr_en), .wr_data(wr_data),
      .status(status), .chg_en(chg_en), .dsg_en(dsg_en), .pre_en(pre_en));

   always #(CLK_P/2) clk = ~clk;

   // reference model built from the requirements
   logic [1:0] m_ps, m_os;
   int         m_cnt;
   logic [2:0] m_req;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ps <= '0; m_os <= '0; m_cnt <= 0; m_req <= '0;
      end else begin
         m_ps <= {m_ps[0], prot_in};
         m_os <= {m_os[0], poweroff_in};
         if (m_ps[1]) m_cnt <= HOLD;
         else if (m_cnt != 0) m_cnt <= m_cnt - 1;
         if (m_ps[1]) m_req <= '0;
         else if (wr_en && !(m_ps[1] || m_cnt != 0)) m_req <= wr_data[2:0];
      end
   end

   function automatic logic [7:0] exp_status();
      logic lock, off, c, d, p;
      lock = m_ps[1] || (m_cnt != 0);
      off  = lock || m_os[1];
      c = m_req[0] & ~off;
      d = m_req[1] & ~off;
      p = m_req[2] & ~off & ~mode_normal;
      return {1'b0, lock, p, d, c, m_req};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4711);
      cyc(3);
      chk("R10 reset status", status, 8'h00);
      chk("R10 reset outputs", {chg_en, dsg_en, pre_en}, 3'b000);
      rst_n = 1'b1;
      cyc(2);

      wr(8'h03);
      chk("R5 enable chg+dsg", status, 8'h1B);
      chk("R5 outputs", {chg_en, dsg_en}, 2'b11);
      wr(8'h07);
      chk("R7 pre blocked in normal mode", status, 8'h1F);
      mode_normal = 1'b0;
      cyc(1);
      chk("R7 pre in recovery mode", pre_en, 1'b1);
      mode_normal = 1'b1;
      wr(8'h78);
      chk("R9 status bits not writable", status, 8'h00);

      wr(8'h03);
      poweroff_in = 1'b1;
      cyc(2);
      chk("R8 poweroff forces off", status, 8'h03);
      poweroff_in = 1'b0;
      cyc(2);
      chk("R8 outputs return", status, 8'h1B);

      prot_in = 1'b1;
      cyc(1);
      chk("R1 sync latency", {chg_en, dsg_en}, 2'b11);
      cyc(1);
      chk("R1 protection off", {chg_en, dsg_en, pre_en}, 3'b000);
      cyc(1);
      chk("R2 requests cleared", status, 8'h40);
      wr(8'h03);
      chk("R4 write in protection ignored", status, 8'h40);

      prot_in = 1'b0;
      cyc(HOLD);
      wr(8'h03);
      chk("R3 lockout before expiry", status, 8'h40);
      chk("R4 late write ignored", {chg_en, dsg_en}, 2'b00);
      cyc(1);
      chk("R3 lockout expired", status, 8'h00);
      cyc(5);
      chk("R6 no automatic enable", {chg_en, dsg_en}, 2'b00);
      wr(8'h03);
      chk("R6 re-enable after write", status, 8'h1B);

      prot_in = 1'b1;
      cyc(3);
      prot_in = 1'b0;
      cyc(10);
      prot_in = 1'b1;
      cyc(1);
      prot_in = 1'b0;
      cyc(HOLD + 1);
      chk("R11 restarted lockout held", status[6], 1'b1);
      cyc(1);
      chk("R11 restarted lockout ends", status[6], 1'b0);

      wr(8'h03);
      prot_in = 1'b1;
      cyc(1);
      wr(8'h07);
      chk("R12 outputs off at collision", {chg_en, dsg_en, pre_en}, 3'b000);
      cyc(1);
      chk("R12 requests cleared", status[2:0], 3'b000);
      prot_in = 1'b0;
      cyc(HOLD + 5);

      for (int i = 0; i < 400; i++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 3) prot_in = 1'b1; else if (r < 12) prot_in = 1'b0;
         r = int'($urandom % 100);
         if (r < 3) poweroff_in = 1'b1; else if (r < 15) poweroff_in = 1'b0;
         if ($urandom % 30 == 0) mode_normal = ~mode_normal;
         wr_en = ($urandom % 3 == 0);
         wr_data = 8'($urandom);
         @(negedge clk);
         chk("R1/R5/R8 random model", status, exp_status());
         chk("R7 random pre_en", {chg_en, dsg_en, pre_en},
             {status[3], status[4], status[5]});
      end
      wr_en = 1'b0;
      summary();
      $finish;
   end
endmodule